// File: doc/BRIEF.md
# Serial receiver status flag controller

This block sits between the receive shift register of an asynchronous serial receiver and the register bus. It holds the last received byte and three status flags: receive-full, idle and overrun. The shift register side delivers a one-cycle character-complete strobe with the assembled byte. The line monitor delivers a one-cycle idle-line strobe.

Software clears the flags with two reads. It reads the status word, then the data register. A flag is cleared by that data read only if it was already set when the status word was read, so a flag that sets between the two reads stays set. A control register holds an overrun interrupt enable, and the block raises an error interrupt request while overrun is set and that enable is on.

Bit sampling, framing, baud generation and the transmitter belong to other blocks.

Top module: `rx_flag_ctrl`

## Requirements
- R1: A character strobe that arrives while receive-full is set, and is not met by a clearing data read, sets overrun. The new byte is discarded and the data register keeps its contents.
- R2: Overrun clears only on a data read (address 1) whose latest preceding status read saw overrun set. A data read that follows a status read taken before overrun was set leaves overrun set.
- R3: The error interrupt request is high exactly while overrun is set and the overrun interrupt enable is 1. The enable is bit 0 of the control register at address 2, which can be read and written.
- R4: An idle strobe sets the idle flag only if a character has loaded the data register since reset or since idle was last cleared. After idle clears, another character must load before idle can set again. Idle reads 1 for an idle line and 0 otherwise.
- R5: Reset clears receive-full, idle, overrun, the interrupt enable and the data register, and holds the interrupt request low.
- R6: Receive-full sets when a character loads. It clears on a data read whose latest preceding status read saw it set. If a character strobe coincides with that clearing read, the read returns the old byte, the new byte loads, and receive-full stays set without overrun.
- R7: A status read (address 0) returns receive-full in bit 5, idle in bit 4 and overrun in bit 3, with all other bits 0. A write to address 0 changes no flag.
- R8: Bus accesses other than a data read, made between the status read and the data read, do not cancel the armed clear. A second status read re-samples which flags are armed.
- R9: Idle clears through the same status-then-data read sequence, and only if idle was set at the status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_done_i | input | 1 | One-cycle strobe: a character has been assembled |
| char_byte_i | input | DW | Assembled byte, valid with char_done_i |
| idle_det_i | input | 1 | One-cycle strobe: idle line detected |
| rd_en_i | input | 1 | Bus read, one cycle per access |
| wr_en_i | input | 1 | Bus write, one cycle per access |
| addr_i | input | 2 | Register address: 0 status, 1 data, 2 control |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational while rd_en_i is high |
| err_irq_o | output | 1 | Error interrupt request (overrun and enable) |

## Verification
The assertions assume that every strobe and every bus access lasts one cycle, and that a read and a write never occur in the same cycle. The idle-gate assertion assumes that a character strobe counts as received, which over-approximates the design's rule, so it can only miss a fault and never fires on a correct design. The bench drives every access through tasks that hold a strobe for exactly one clock and release it after the edge. The bench never asserts rd_en_i and wr_en_i together. It raises a character strobe together with a data read only in the deliberate same-cycle case of R6.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] A_STAT = 2'd0;
  localparam logic [AW-1:0] A_DATA = 2'd1;
  localparam logic [AW-1:0] A_CTRL = 2'd2;
  localparam int unsigned B_FULL = 5;
  localparam int unsigned B_IDLE = 4;
  localparam int unsigned B_OVR  = 3;

  typedef struct packed {
    logic full;
    logic idle;
    logic ovr;
  } flags_t;
endpackage

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= byte_i;
  end
endmodule

// File: rtl/rx_flag_core.sv
module rx_flag_core
  import rx_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   char_done_i,
  input  logic   idle_det_i,
  input  logic   stat_rd_i,
  input  logic   data_rd_i,
  output flags_t flags_o,
  output logic   load_o
);
  flags_t flags_q, arm_q;
  logic   seen_q;
  logic   clr_full, clr_idle, clr_ovr;

  assign clr_full = data_rd_i & arm_q.full;
  assign clr_idle = data_rd_i & arm_q.idle;
  assign clr_ovr  = data_rd_i & arm_q.ovr;
  // a clearing read frees the register for a coincident character
  assign load_o   = char_done_i & (~flags_q.full | clr_full);

  // arm at the status read, consume at the data read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= '0;
    else if (stat_rd_i) arm_q <= flags_q;
    else if (data_rd_i) arm_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (load_o)        flags_q.full <= 1'b1;
      else if (clr_full) flags_q.full <= 1'b0;

      if (char_done_i && !load_o) flags_q.ovr <= 1'b1;
      else if (clr_ovr)           flags_q.ovr <= 1'b0;

      if (load_o)        seen_q <= 1'b1;
      else if (clr_idle) seen_q <= 1'b0;

      if (clr_idle)                  flags_q.idle <= 1'b0;
      else if (idle_det_i && seen_q) flags_q.idle <= 1'b1;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rx_bus_port.sv
module rx_bus_port
  import rx_flag_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  flags_t        flags_i,
  input  logic [DW-1:0] data_i,
  output logic          stat_rd_o,
  output logic          data_rd_o,
  output logic          ovr_ie_o,
  output logic [DW-1:0] rdata_o
);
  logic ie_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:1];
  assign stat_rd_o    = rd_en_i & (addr_i == A_STAT);
  assign data_rd_o    = rd_en_i & (addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ie_q <= 1'b0;
    else if (wr_en_i && addr_i == A_CTRL)   ie_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_STAT: begin
          rdata_o[B_FULL] = flags_i.full;
          rdata_o[B_IDLE] = flags_i.idle;
          rdata_o[B_OVR]  = flags_i.ovr;
        end
        A_DATA:  rdata_o    = data_i;
        A_CTRL:  rdata_o[0] = ie_q;
        default: rdata_o    = '0;
      endcase
    end
  end

  assign ovr_ie_o = ie_q;
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import rx_flag_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          char_done_i,
  input  logic [DW-1:0] char_byte_i,
  input  logic          idle_det_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_irq_o
);
  flags_t        flags;
  logic          load, stat_rd, data_rd, ovr_ie;
  logic [DW-1:0] data_q;

  rx_flag_core u_core (
    .clk_i, .rst_ni, .char_done_i, .idle_det_i,
    .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .flags_o(flags), .load_o(load)
  );

  rx_data_hold #(.DW(DW)) u_hold (
    .clk_i, .rst_ni, .load_i(load), .byte_i(char_byte_i), .data_o(data_q)
  );

  rx_bus_port #(.DW(DW)) u_port (
    .clk_i, .rst_ni, .rd_en_i, .wr_en_i, .addr_i, .wdata_i,
    .flags_i(flags), .data_i(data_q),
    .stat_rd_o(stat_rd), .data_rd_o(data_rd), .ovr_ie_o(ovr_ie), .rdata_o
  );

  assign err_irq_o = flags.ovr & ovr_ie;
endmodule

// File: rtl/rx_flag_chk.sv
module rx_flag_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          char_done_i,
  input logic          idle_det_i,
  input logic          rd_en_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          err_irq_o,
  input logic          full,
  input logic          idle,
  input logic          ovr,
  input logic          ie,
  input logic [DW-1:0] data_q
);
  logic stat_rd, data_rd, saw_ovr_q, any_char_q, idle_d_q, char_d_q;
  assign stat_rd = rd_en_i && addr_i == 2'd0;
  assign data_rd = rd_en_i && addr_i == 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saw_ovr_q  <= 1'b0;
      any_char_q <= 1'b0;
      idle_d_q   <= 1'b0;
      char_d_q   <= 1'b0;
    end else begin
      idle_d_q <= idle;
      char_d_q <= char_done_i;
      if (stat_rd)      saw_ovr_q <= rdata_o[3];
      else if (data_rd) saw_ovr_q <= 1'b0;
      if (char_done_i)                         any_char_q <= 1'b1;
      else if (idle_d_q && !idle && !char_d_q) any_char_q <= 1'b0;
    end
  end

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && full && !rd_en_i) |=> ovr) else $error("ovr"); // R1
  AST_DATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && full && !rd_en_i) |=> $stable(data_q)) else $error("data"); // R1
  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && ovr && !saw_ovr_q) |=> ovr) else $error("ovr hold"); // R2
  AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && ie) |-> err_irq_o) else $error("irq"); // R3
  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !err_irq_o) else $error("irq off"); // R3
  AST_IDLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !any_char_q && !char_done_i) |=> !idle) else $error("idle"); // R4
  AST_STAT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> (rdata_o[7:6] == 2'b0 && rdata_o[2:0] == 3'b0)) else $error("pad"); // R7
endmodule

bind rx_flag_ctrl rx_flag_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .char_done_i, .idle_det_i, .rd_en_i, .addr_i, .rdata_o, .err_irq_o,
  .full(flags.full), .idle(flags.idle), .ovr(flags.ovr), .ie(ovr_ie), .data_q(data_q)
);

// File: tb/sim_rx_flag_ctrl.sv
`timescale 1ns/1ps
module sim_rx_flag_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       char_done = 1'b0, idle_det = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] char_byte = '0, wdata = '0;
  logic [1:0] addr = '0;
  logic [7:0] rdata;
  logic       err_irq;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  rx_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .char_done_i(char_done), .char_byte_i(char_byte),
    .idle_det_i(idle_det), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_irq_o(err_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input bit f, input bit i, input bit o);
    return 8'(f) * 8'd32 + 8'(i) * 8'd16 + 8'(o) * 8'd8;
  endfunction

  task automatic put_char(input logic [7:0] b);
    @(negedge clk); char_done = 1'b1; char_byte = b;
    @(posedge clk); #1 char_done = 1'b0;
  endtask

  task automatic idle_pulse();
    @(negedge clk); idle_det = 1'b1;
    @(posedge clk); #1 idle_det = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    bus_rd(2'd0, v); check("R5 reset status", v, 8'h00);
    bus_rd(2'd1, v); check("R5 reset data", v, 8'h00);
    bus_rd(2'd2, v); check("R5 reset ie", v, 8'h00);
    check("R5 reset irq", {7'd0, err_irq}, 8'h00);

    // normal sequence, four bytes
    for (int k = 1; k <= 4; k++) begin
      put_char(8'(k * 17));
      bus_rd(2'd0, v); check("R6 normal status", v, stat(1, 0, 0));
      bus_rd(2'd1, v); check("R6 normal data", v, 8'(k * 17));
    end
    bus_rd(2'd0, v); check("R6 full cleared", v, stat(0, 0, 0));

    // delayed sequence with ie swept
    for (int ie = 0; ie < 2; ie++) begin
      do_reset();
      bus_wr(2'd2, 8'(ie));
      put_char(8'hB1);
      bus_rd(2'd0, v); check("R1 delayed status1", v, stat(1, 0, 0));
      put_char(8'hB2);
      check("R3 irq level", {7'd0, err_irq}, 8'(ie));
      bus_rd(2'd1, v); check("R1 byte1 kept", v, 8'hB1);
      bus_rd(2'd0, v); check("R2 ovr survives unarmed read", v, stat(0, 0, 1));
      put_char(8'hB3);
      bus_rd(2'd0, v); check("R2 status2", v, stat(1, 0, 1));
      bus_rd(2'd1, v); check("R1 byte2 lost", v, 8'hB3);
      bus_rd(2'd0, v); check("R2 ovr cleared", v, stat(0, 0, 0));
      check("R3 irq low", {7'd0, err_irq}, 8'h00);
      put_char(8'hB4);
      bus_rd(2'd0, v); bus_rd(2'd1, v); check("R6 byte4", v, 8'hB4);
    end

    // same-cycle char and clearing read
    do_reset();
    put_char(8'h5A);
    bus_rd(2'd0, v);
    @(negedge clk); rd_en = 1'b1; addr = 2'd1; char_done = 1'b1; char_byte = 8'hA5;
    #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0; char_done = 1'b0;
    check("R6 coincident old byte", v, 8'h5A);
    bus_rd(2'd0, v); check("R6 full stays, no ovr", v, stat(1, 0, 0));
    bus_rd(2'd1, v); check("R6 new byte loaded", v, 8'hA5);

    // idle gating
    do_reset();
    idle_pulse();
    bus_rd(2'd0, v); check("R4 idle blocked after reset", v, stat(0, 0, 0));
    put_char(8'h11);
    idle_pulse();
    bus_rd(2'd0, v); check("R4 idle set", v, stat(1, 1, 0));
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd2, v);
    bus_rd(2'd0, v); check("R7 status write ignored", v, stat(1, 1, 0));
    bus_rd(2'd1, v);
    bus_rd(2'd0, v); check("R9 idle cleared", v, stat(0, 0, 0));
    idle_pulse();
    bus_rd(2'd0, v); check("R4 idle needs new char", v, stat(0, 0, 0));
    put_char(8'h22);
    bus_rd(2'd0, v);
    idle_pulse();
    bus_rd(2'd1, v);
    bus_rd(2'd0, v); check("R9 idle unarmed stays", v, stat(0, 1, 0));

    // other accesses keep arm; re-sample on second status read
    do_reset();
    put_char(8'h33);
    bus_rd(2'd0, v);
    bus_rd(2'd2, v);
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd1, v);
    bus_rd(2'd0, v); check("R8 arm kept across accesses", v, stat(0, 0, 0));
    put_char(8'h44);
    bus_rd(2'd0, v);
    put_char(8'h55);
    bus_rd(2'd0, v); check("R8 resample sees ovr", v, stat(1, 0, 1));
    check("R3 irq set", {7'd0, err_irq}, 8'h01);
    bus_rd(2'd1, v);
    bus_rd(2'd0, v); check("R8 both cleared", v, stat(0, 0, 0));

    // reset mid-run
    put_char(8'h66); put_char(8'h77);
    do_reset();
    bus_rd(2'd0, v); check("R5 midrun reset", v, 8'h00);
    check("R5 midrun irq", {7'd0, err_irq}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule